// File: doc/BRIEF.md
# Auto-increment word program sequencer

This block writes a byte range into a serial flash device that is programmed with an auto-address-increment word command rather than a page command. It takes a start address and a byte count, pulls the data bytes from a stream input, and drives a byte-level SPI command port. The SPI shifter itself and the chip select logic sit outside the block. Each byte the port moves is one transfer, and a flag marks the last byte of a chip-select frame.

The sequence opens with a readiness poll and a write-enable. An odd start address is covered by a single-byte program. The aligned middle goes out in two-byte words: the first word carries opcode and address, and every later word carries only the opcode. A write-disable closes the word phase. A remaining odd tail byte is then written with its own write-enable, single-byte program and write-disable. After every program command the block polls the status register until the busy bit clears. Too many busy answers in a row abort the run with a timeout flag.

On completion the block pulses `done` and reports how many bytes were confirmed written. A zero count finishes at once. A range that runs past the device size is refused before any traffic.

Top module: `aai_prog_seq`

## Requirements
- R1: After reset `busy`, `done`, `spi_req`, `dat_take`, both error flags and `written` are all 0.
- R2: A start with count 0 produces no SPI transfer and raises `done` in the next cycle, with `written` 0 and no error flag.
- R3: A start whose address plus count exceeds DEV_SIZE produces no SPI transfer and ends with `done`, `err_range` = 1 and `written` = 0. Address plus count equal to DEV_SIZE is accepted.
- R4: A readiness poll is a two-byte frame, 0x05 and then a filler byte 0x00 that carries the end flag. Bit 0 of the byte received with the filler set to 1 means busy, and the poll frame repeats until that bit reads 0; the other received bits are ignored.
- R5: Every accepted run starts with a poll and then a one-byte write-enable frame 0x06.
- R6: With an odd start address, the next frame is 0x02, then the address bytes most significant first, then one data byte, followed by a poll.
- R7: While at least two bytes remain, a word frame is sent: 0xAD, then the address (first word of the run only), then two data bytes, followed by a poll.
- R8: After the word phase, including when it sent no word, a one-byte write-disable frame 0x04 is sent, followed by a poll.
- R9: If one byte then remains, the block sends 0x06, then 0x02 with that byte's address and the byte, then a poll, then 0x04, and then completes.
- R10: When POLL_LIMIT consecutive polls of one wait all read busy, the run stops with `done` and `err_timeout` = 1. `written` then counts only the bytes whose program command was followed by a successful poll. The next start clears the flag.
- R11: A successful run ends with `written` equal to the count and both error flags 0; `written` never decreases during a run.
- R12: A data byte is popped (`dat_take`) only in the cycle it is transferred, which needs both `dat_valid` and `spi_ack`; while `dat_valid` is low the data transfer waits.
- R13: `done` is a single-cycle pulse raised while `busy` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a run (sampled while idle) |
| start_addr | input | 8*ADDR_BYTES | First byte address |
| start_count | input | CNT_W | Number of bytes to write |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle completion pulse |
| err_timeout | output | 1 | Last run stopped on a poll timeout |
| err_range | output | 1 | Last run refused for range |
| written | output | CNT_W | Bytes confirmed written by the last run |
| spi_req | output | 1 | Byte offered to the SPI port |
| spi_tx | output | 8 | Byte to shift out |
| spi_end | output | 1 | This byte closes the chip-select frame |
| spi_ack | input | 1 | Port moves the offered byte this cycle |
| spi_rx | input | 8 | Byte shifted in during the acknowledged transfer |
| dat_valid | input | 1 | Stream byte available |
| dat_byte | input | 8 | Stream byte |
| dat_take | output | 1 | Stream byte consumed this cycle |

## Verification
The assertions assume that `spi_ack` is only high while `spi_req` is high, that `spi_rx` is meaningful in an acknowledged cycle, and that `start` is not raised during the cycle in which `done` is high. The bench model acknowledges only offered bytes and delays some acknowledges, and it fills `spi_rx` only when it accepts a byte. It raises `start` only after the `done` pulse has been seen and cleared. Stream gaps come from a fixed cycle pattern, so stalls land inside data phases of both address-carrying and opcode-only frames.

// File: rtl/aai_prog_pkg.sv
package aai_prog_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_POLL_OP,
        S_POLL_RD,
        S_OPC,
        S_ADR,
        S_DAT
    } state_e;

    typedef enum logic [2:0] {
        J_POLL0,
        J_WREN,
        J_HEAD,
        J_WORD,
        J_WRDI,
        J_TWREN,
        J_TAIL,
        J_TWRDI
    } job_e;

    localparam logic [7:0] OP_STATUS = 8'h05;
    localparam logic [7:0] OP_WEN    = 8'h06;
    localparam logic [7:0] OP_WDIS   = 8'h04;
    localparam logic [7:0] OP_BYTE   = 8'h02;
    localparam logic [7:0] OP_AAI    = 8'hAD;
    localparam logic [7:0] POLL_FILL = 8'h00;
    localparam logic [7:0] BUSY_MASK = 8'h01;

endpackage

// File: rtl/aai_range_chk.sv
module aai_range_chk #(
    parameter int          ADDR_W   = 24,
    parameter int          CNT_W    = 16,
    parameter int unsigned DEV_SIZE = 32'h0010_0000
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [CNT_W-1:0]  count,
    output logic              too_far
);
    localparam int SUM_W = ((ADDR_W > CNT_W) ? ADDR_W : CNT_W) + 1;

    logic [SUM_W-1:0] end_excl;

    always_comb begin
        end_excl = SUM_W'(addr) + SUM_W'(count);
        too_far  = end_excl > SUM_W'(DEV_SIZE);
    end
endmodule

// File: rtl/aai_poll_timer.sv
module aai_poll_timer #(
    parameter int POLL_LIMIT = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic bump,
    output logic expired
);
    localparam int TW = $clog2(POLL_LIMIT + 1);
    localparam logic [TW-1:0] LAST = TW'(POLL_LIMIT - 1);

    logic [TW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clr)
            cnt_d = '0;
        else if (bump && cnt_q != LAST)
            cnt_d = cnt_q + TW'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign expired = (cnt_q == LAST);

    // R10
    cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LAST);
endmodule

// File: rtl/aai_addr_pick.sv
module aai_addr_pick #(
    parameter int NB    = 3,
    parameter int IDX_W = 2
) (
    input  logic [8*NB-1:0]  addr,
    input  logic [IDX_W-1:0] idx,
    output logic [7:0]       byte_o
);
    localparam logic [IDX_W-1:0] LAST = IDX_W'(NB - 1);

    logic [7:0] lanes [NB];

    for (genvar g = 0; g < NB; g++) begin : g_lane
        assign lanes[g] = addr[8*(NB-1-g) +: 8];
    end

    always_comb begin
        byte_o = '0;
        if (idx <= LAST) byte_o = lanes[idx];
    end
endmodule

// File: rtl/aai_frame_shape.sv
module aai_frame_shape
    import aai_prog_pkg::*;
(
    input  job_e       job,
    input  logic       first_word,
    output logic [7:0] opcode,
    output logic       has_addr,
    output logic [1:0] n_data
);
    always_comb begin
        opcode   = OP_WDIS;
        has_addr = 1'b0;
        n_data   = 2'd0;
        case (job)
            J_WREN, J_TWREN: opcode = OP_WEN;
            J_HEAD, J_TAIL: begin
                opcode   = OP_BYTE;
                has_addr = 1'b1;
                n_data   = 2'd1;
            end
            J_WORD: begin
                opcode   = OP_AAI;
                has_addr = first_word;
                n_data   = 2'd2;
            end
            default: opcode = OP_WDIS;
        endcase
    end
endmodule

// File: rtl/aai_prog_seq.sv
module aai_prog_seq
    import aai_prog_pkg::*;
#(
    parameter int          ADDR_BYTES = 3,
    parameter int          CNT_W      = 16,
    parameter int unsigned DEV_SIZE   = 32'h0010_0000,
    parameter int          POLL_LIMIT = 64
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    start,
    input  logic [8*ADDR_BYTES-1:0] start_addr,
    input  logic [CNT_W-1:0]        start_count,
    output logic                    busy,
    output logic                    done,
    output logic                    err_timeout,
    output logic                    err_range,
    output logic [CNT_W-1:0]        written,
    output logic                    spi_req,
    output logic [7:0]              spi_tx,
    output logic                    spi_end,
    input  logic                    spi_ack,
    input  logic [7:0]              spi_rx,
    input  logic                    dat_valid,
    input  logic [7:0]              dat_byte,
    output logic                    dat_take
);
    localparam int ADDR_W = 8 * ADDR_BYTES;
    localparam int AIDX_W = (ADDR_BYTES > 1) ? $clog2(ADDR_BYTES) : 1;
    localparam logic [AIDX_W-1:0] AIDX_LAST = AIDX_W'(ADDR_BYTES - 1);

    typedef struct packed {
        state_e             st;
        job_e               job;
        logic [ADDR_W-1:0]  addr;
        logic [CNT_W-1:0]   rem;
        logic [CNT_W-1:0]   wr;
        logic [1:0]         pend;
        logic [1:0]         didx;
        logic [AIDX_W-1:0]  aidx;
        logic               first;
        logic               done;
        logic               e_to;
        logic               e_rng;
    } seq_t;

    seq_t seq_d, seq_q;

    logic       range_bad;
    logic       tmr_clr, tmr_bump, tmr_expired;
    logic [7:0] fr_opcode, adr_byte;
    logic       fr_has_addr;
    logic [1:0] fr_n_data;
    logic       poll_busy;

    aai_range_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .DEV_SIZE(DEV_SIZE)) u_range (
        .addr(start_addr), .count(start_count), .too_far(range_bad)
    );

    aai_poll_timer #(.POLL_LIMIT(POLL_LIMIT)) u_timer (
        .clk(clk), .rst_n(rst_n), .clr(tmr_clr), .bump(tmr_bump), .expired(tmr_expired)
    );

    aai_frame_shape u_shape (
        .job(seq_q.job), .first_word(seq_q.first),
        .opcode(fr_opcode), .has_addr(fr_has_addr), .n_data(fr_n_data)
    );

    aai_addr_pick #(.NB(ADDR_BYTES), .IDX_W(AIDX_W)) u_apick (
        .addr(seq_q.addr), .idx(seq_q.aidx), .byte_o(adr_byte)
    );

    assign poll_busy = |(spi_rx & BUSY_MASK);

    function automatic seq_t launch(input seq_t s, input job_e j);
        seq_t r = s;
        r.st   = S_OPC;
        r.job  = j;
        r.aidx = '0;
        r.didx = '0;
        return r;
    endfunction

    function automatic seq_t finish(input seq_t s);
        seq_t r = s;
        r.st   = S_IDLE;
        r.done = 1'b1;
        return r;
    endfunction

    function automatic seq_t go_words(input seq_t s);
        if (s.rem >= CNT_W'(2)) return launch(s, J_WORD);
        return launch(s, J_WRDI);
    endfunction

    function automatic seq_t frame_end(input seq_t s);
        seq_t r = s;
        if (r.job == J_WORD) r.first = 1'b0;
        case (r.job)
            J_WREN:  r = r.addr[0] ? launch(r, J_HEAD) : go_words(r);
            J_HEAD, J_WORD, J_WRDI, J_TAIL: r.st = S_POLL_OP;
            J_TWREN: r = launch(r, J_TAIL);
            default: r = finish(r);
        endcase
        return r;
    endfunction

    always_comb begin
        seq_d      = seq_q;
        seq_d.done = 1'b0;
        spi_req    = 1'b0;
        spi_tx     = '0;
        spi_end    = 1'b0;
        dat_take   = 1'b0;
        tmr_clr    = 1'b0;
        tmr_bump   = 1'b0;

        case (seq_q.st)
            S_IDLE: begin
                if (start) begin
                    seq_d.wr    = '0;
                    seq_d.pend  = '0;
                    seq_d.e_to  = 1'b0;
                    seq_d.e_rng = 1'b0;
                    seq_d.first = 1'b1;
                    seq_d.addr  = start_addr;
                    seq_d.rem   = start_count;
                    tmr_clr     = 1'b1;
                    if (start_count == '0) begin
                        seq_d = finish(seq_d);
                    end else if (range_bad) begin
                        seq_d.e_rng = 1'b1;
                        seq_d = finish(seq_d);
                    end else begin
                        seq_d.job = J_POLL0;
                        seq_d.st  = S_POLL_OP;
                    end
                end
            end

            S_POLL_OP: begin
                spi_req = 1'b1;
                spi_tx  = OP_STATUS;
                if (spi_ack) seq_d.st = S_POLL_RD;
            end

            S_POLL_RD: begin
                spi_req = 1'b1;
                spi_tx  = POLL_FILL;
                spi_end = 1'b1;
                if (spi_ack) begin
                    if (poll_busy) begin
                        if (tmr_expired) begin
                            tmr_clr    = 1'b1;
                            seq_d.e_to = 1'b1;
                            seq_d      = finish(seq_d);
                        end else begin
                            tmr_bump = 1'b1;
                            seq_d.st = S_POLL_OP;
                        end
                    end else begin
                        tmr_clr    = 1'b1;
                        seq_d.wr   = seq_q.wr + CNT_W'(seq_q.pend);
                        seq_d.pend = '0;
                        case (seq_q.job)
                            J_POLL0:        seq_d = launch(seq_d, J_WREN);
                            J_HEAD, J_WORD: seq_d = go_words(seq_d);
                            J_WRDI:         seq_d = (seq_d.rem != '0) ? launch(seq_d, J_TWREN)
                                                                      : finish(seq_d);
                            J_TAIL:         seq_d = launch(seq_d, J_TWRDI);
                            default:        seq_d = finish(seq_d);
                        endcase
                    end
                end
            end

            S_OPC: begin
                spi_req = 1'b1;
                spi_tx  = fr_opcode;
                spi_end = !fr_has_addr && (fr_n_data == 2'd0);
                if (spi_ack) begin
                    if (fr_has_addr)              seq_d.st = S_ADR;
                    else if (fr_n_data != 2'd0)   seq_d.st = S_DAT;
                    else                          seq_d = frame_end(seq_d);
                end
            end

            S_ADR: begin
                spi_req = 1'b1;
                spi_tx  = adr_byte;
                spi_end = (seq_q.aidx == AIDX_LAST) && (fr_n_data == 2'd0);
                if (spi_ack) begin
                    seq_d.aidx = seq_q.aidx + AIDX_W'(1);
                    if (seq_q.aidx == AIDX_LAST) begin
                        if (fr_n_data != 2'd0) seq_d.st = S_DAT;
                        else                   seq_d = frame_end(seq_d);
                    end
                end
            end

            S_DAT: begin
                spi_req  = dat_valid;
                spi_tx   = dat_byte;
                spi_end  = dat_valid && (seq_q.didx == fr_n_data - 2'd1);
                dat_take = dat_valid && spi_ack;
                if (dat_valid && spi_ack) begin
                    seq_d.addr = seq_q.addr + ADDR_W'(1);
                    seq_d.rem  = seq_q.rem - CNT_W'(1);
                    seq_d.pend = seq_q.pend + 2'd1;
                    seq_d.didx = seq_q.didx + 2'd1;
                    if (seq_q.didx == fr_n_data - 2'd1) seq_d = frame_end(seq_d);
                end
            end

            default: seq_d = finish(seq_d);
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q       <= '0;
            seq_q.st    <= S_IDLE;
            seq_q.job   <= J_POLL0;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign busy        = (seq_q.st != S_IDLE);
    assign done        = seq_q.done;
    assign err_timeout = seq_q.e_to;
    assign err_range   = seq_q.e_rng;
    assign written     = seq_q.wr;

    // R4
    end_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        spi_end |-> spi_req);

    // R12
    take_needs_xfer_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dat_take |-> (dat_valid && spi_ack));

    // R13
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    // R3
    range_nowrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_range |-> (written == '0 && !err_timeout));

    // R11
    wr_monotonic_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> (written >= $past(written)));

    // R5
    opens_with_poll_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> (spi_req && spi_tx == OP_STATUS && !spi_end));

    // R2
    zero_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && start_count == '0) |=> (done && !busy));
endmodule

// File: tb/aai_prog_seq_bench.sv
module aai_prog_seq_bench;
    localparam int CLK_P    = 10;
    localparam int LIMIT    = 8;
    localparam int DEVSZ    = 4096;
    localparam int LOGMAX   = 1024;

    typedef struct packed {
        int unsigned a;
        int unsigned c;
        int unsigned b;
        int unsigned g;
    } vec_t;

    localparam vec_t VECS [8] = '{
        '{32'd16,   32'd6, 32'd0, 32'd0},
        '{32'd33,   32'd5, 32'd0, 32'd0},
        '{32'd33,   32'd4, 32'd1, 32'd0},
        '{32'd40,   32'd1, 32'd0, 32'd0},
        '{32'd41,   32'd1, 32'd2, 32'd0},
        '{32'd100,  32'd2, 32'd0, 32'd1},
        '{32'd7,    32'd9, 32'd3, 32'd1},
        '{32'd4094, 32'd2, 32'd0, 32'd0}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [23:0] start_addr = '0;
    logic [15:0] start_count = '0;
    logic        busy, done, err_timeout, err_range;
    logic [15:0] written;
    logic        spi_req, spi_end, spi_ack;
    logic [7:0]  spi_tx, spi_rx;
    logic        dat_valid;
    logic [7:0]  dat_byte;
    logic        dat_take;

    int checks = 0;
    int fails  = 0;

    // device and stream model state
    int   busy_cfg = 0, busy_left = 0, ok_left = -1;
    int   frame_pos = 0, tail_polls = 0, gap_mode = 0, dat_idx = 0, cyc = 0;
    int   take_bad = 0, seed_v = 0;
    logic [7:0] frame_op = '0;
    int   log_n = 0;
    logic [7:0] log_b [LOGMAX];
    logic       log_e [LOGMAX];
    int   exp_n = 0;
    logic [7:0] exp_b [LOGMAX];
    logic       exp_e [LOGMAX];

    aai_prog_seq #(.ADDR_BYTES(3), .CNT_W(16), .DEV_SIZE(DEVSZ), .POLL_LIMIT(LIMIT)) u_aai_prog_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .start_addr(start_addr),
        .start_count(start_count), .busy(busy), .done(done),
        .err_timeout(err_timeout), .err_range(err_range), .written(written),
        .spi_req(spi_req), .spi_tx(spi_tx), .spi_end(spi_end), .spi_ack(spi_ack),
        .spi_rx(spi_rx), .dat_valid(dat_valid), .dat_byte(dat_byte), .dat_take(dat_take)
    );

    always #(CLK_P/2) clk = ~clk;

    function automatic logic [7:0] dpat(input int v, input int i);
        return 8'((i * 37) + (v * 11) + 5);
    endfunction

    always @(negedge clk) begin
        cyc++;
        dat_valid = !(gap_mode != 0 && (cyc % 3) == 0);
        dat_byte  = dpat(seed_v, dat_idx);
        #1;
        spi_ack = spi_req && !(gap_mode != 0 && (cyc % 4) == 1);
        spi_rx  = 8'h00;
        if (spi_ack) begin
            if (frame_pos == 1 && frame_op == 8'h05) begin
                if (ok_left == 0 || busy_left > 0) begin
                    spi_rx = 8'h03;
                    if (busy_left > 0) busy_left--;
                end else begin
                    spi_rx = 8'h02;
                    busy_left = busy_cfg;
                    if (ok_left > 0) ok_left--;
                end
            end
            if (log_n < LOGMAX) begin
                log_b[log_n] = spi_tx;
                log_e[log_n] = spi_end;
            end
            log_n++;
            if (frame_pos == 0) frame_op = spi_tx;
            frame_pos++;
            if (spi_end) begin
                if (frame_op == 8'h05) tail_polls++;
                else                   tail_polls = 0;
                frame_pos = 0;
            end
        end
        #1;
        if (dat_take && !dat_valid) take_bad++;
        if (dat_take) dat_idx++;
    end

    task automatic chk(input bit ok, input string tag, input int act, input int expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
        end
    endtask

    task automatic push(input logic [7:0] b, input logic e);
        if (exp_n < LOGMAX) begin
            exp_b[exp_n] = b;
            exp_e[exp_n] = e;
        end
        exp_n++;
    endtask

    task automatic push_poll(input int nbusy);
        for (int k = 0; k <= nbusy; k++) begin
            push(8'h05, 1'b0);
            push(8'h00, 1'b1);
        end
    endtask

    task automatic push_addr(input int a);
        push(8'(a >> 16), 1'b0);
        push(8'(a >> 8), 1'b0);
        push(8'(a), 1'b0);
    endtask

    // expected frame stream built from R4..R9
    task automatic build_exp(input int a, input int c, input int nb, input int v);
        int i;
        int cur;
        bit first;
        exp_n = 0;
        i = 0;
        cur = a;
        first = 1'b1;
        push_poll(nb);
        push(8'h06, 1'b1);
        if ((a % 2) == 1) begin
            push(8'h02, 1'b0);
            push_addr(cur);
            push(dpat(v, 0), 1'b1);
            push_poll(nb);
            i = 1;
            cur++;
        end
        while (c - i >= 2) begin
            push(8'hAD, 1'b0);
            if (first) push_addr(cur);
            push(dpat(v, i), 1'b0);
            push(dpat(v, i + 1), 1'b1);
            push_poll(nb);
            i += 2;
            cur += 2;
            first = 1'b0;
        end
        push(8'h04, 1'b1);
        push_poll(nb);
        if (i < c) begin
            push(8'h06, 1'b1);
            push(8'h02, 1'b0);
            push_addr(cur);
            push(dpat(v, i), 1'b1);
            push_poll(nb);
            push(8'h04, 1'b1);
        end
    endtask

    task automatic prep(input int nb, input int okl, input int gap, input int v);
        busy_cfg = nb;
        busy_left = nb;
        ok_left = okl;
        gap_mode = gap;
        seed_v = v;
        dat_idx = 0;
        log_n = 0;
        frame_pos = 0;
        tail_polls = 0;
        take_bad = 0;
    endtask

    task automatic kick(input int a, input int c);
        @(negedge clk);
        start = 1'b1;
        start_addr = 24'(a);
        start_count = 16'(c);
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_done(output bit seen, output bit busy_at_done);
        seen = 1'b0;
        busy_at_done = 1'b0;
        for (int k = 0; k < 4000; k++) begin
            #3;
            if (done) begin
                seen = 1'b1;
                busy_at_done = busy;
                break;
            end
            @(negedge clk);
        end
        @(negedge clk);
        #3;
    endtask

    initial begin
        #(CLK_P * 150000);
        fails++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        bit seen, bsy;
        int bad;
        spi_ack = 1'b0;
        spi_rx = '0;
        dat_valid = 1'b0;
        dat_byte = '0;
        repeat (3) @(negedge clk);
        #3;
        // R1 reset state
        chk(!busy && !done, "R1 busy/done after reset", int'(busy), 0);
        chk(!spi_req && !dat_take, "R1 no requests after reset", int'(spi_req), 0);
        chk(!err_timeout && !err_range && written == 0, "R1 flags and written after reset", int'(written), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        foreach (VECS[j]) begin
            prep(int'(VECS[j].b), -1, int'(VECS[j].g), j);
            build_exp(int'(VECS[j].a), int'(VECS[j].c), int'(VECS[j].b), j);
            kick(int'(VECS[j].a), int'(VECS[j].c));
            wait_done(seen, bsy);
            chk(seen && !bsy, "R13 done pulse with busy low", int'(seen), 1);
            bad = -1;
            for (int k = 0; k < exp_n && k < LOGMAX; k++) begin
                if (bad < 0 && (k >= log_n || log_b[k] !== exp_b[k] || log_e[k] !== exp_e[k]))
                    bad = k;
            end
            chk(bad < 0 && log_n == exp_n, "R4 R5 R6 R7 R8 R9 frame stream (mismatch index / len)",
                (bad < 0) ? log_n : bad, (bad < 0) ? exp_n : -1);
            chk(written == 16'(VECS[j].c), "R11 written equals count", int'(written), int'(VECS[j].c));
            chk(!err_timeout && !err_range, "R11 no error flags", int'(err_timeout) + int'(err_range), 0);
            chk(take_bad == 0 && dat_idx == int'(VECS[j].c), "R12 pops match transfers", dat_idx, int'(VECS[j].c));
        end

        // R2 zero count
        prep(0, -1, 0, 20);
        kick(100, 0);
        #3;
        chk(done === 1'b1 && !busy, "R2 done in cycle after start", int'(done), 1);
        wait_done(seen, bsy);
        chk(log_n == 0 && written == 0 && !err_range && !err_timeout, "R2 no traffic for zero count", log_n, 0);

        // R3 range refused
        prep(0, -1, 0, 21);
        kick(DEVSZ - 1, 2);
        wait_done(seen, bsy);
        chk(seen && err_range, "R3 err_range on overrun", int'(err_range), 1);
        chk(log_n == 0 && written == 0, "R3 no traffic on overrun", log_n, 0);

        // R10 timeout after one confirmed word
        prep(0, 2, 0, 22);
        kick(0, 6);
        wait_done(seen, bsy);
        chk(seen && err_timeout && !err_range, "R10 timeout flag", int'(err_timeout), 1);
        chk(written == 2, "R10 written counts confirmed bytes", int'(written), 2);
        chk(tail_polls == LIMIT, "R10 poll attempts before giving up", tail_polls, LIMIT);

        // R10 next start clears the flag
        prep(0, -1, 0, 23);
        build_exp(200, 3, 0, 23);
        kick(200, 3);
        wait_done(seen, bsy);
        chk(!err_timeout && written == 3, "R10 flag cleared by next run", int'(err_timeout), 0);
        chk(log_n == exp_n, "R8 stream length after recovery", log_n, exp_n);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule